// File: doc/BRIEF.md
# Fractional-Stretch Reload Timer

This block is an 8-bit down-counting timer that reloads itself. Software writes a reload value, strobes a preset to copy that value into the counter, and then starts the timer. The counter steps down by one on each cycle where the count-clock enable is high. When it passes zero, the counter takes the reload value again and a one-cycle underflow pulse appears. That pulse serves both as the bit-rate clock for a serial transmitter and as the timer interrupt request.

With a plain reload value, only integer divisions of the count clock can be produced. A 4-bit fine-adjust value F closes the gap. Out of every group of 16 consecutive underflow periods, exactly F periods are held one extra count clock at zero before they underflow. The held periods are spread evenly over the group by a bit-reversed slot order. Over 16 periods the total is (reload+1)*16 + F count clocks.

Control is a three-state machine. ST_IDLE is stopped. ST_COUNT is counting down. ST_STRETCH is the single inserted count clock that is held at zero. The transitions are:
- START (IDLE to COUNT) on run_set.
- HALT (COUNT or STRETCH to IDLE) on run_clr.
- HOLD (COUNT to STRETCH) when the count is at zero on a tick and the slot is due a stretch.
- WRAP (COUNT or STRETCH back to COUNT) on underflow in repeat mode.
- SHOT_END (to IDLE) on underflow in one-shot mode.
- PRESET_ABORT (STRETCH to COUNT) on a preset.

Top module: `frac_reload_timer`

## Requirements
- R1: After asynchronous reset, count is 0, running is 0, and uf_out and irq are both 0.
- R2: A preset loads count with reload_val on the next clock edge and returns the stretch slot index to 0. A preset takes priority over a tick in the same cycle.
- R3: While running, each cycle with tick_en high lowers a nonzero count by one. A cycle with tick_en low, or a cycle while stopped, leaves count unchanged.
- R4: With fine = 0, underflow pulses are exactly reload+1 ticks apart. At each underflow, count is reloaded with reload_val.
- R5: Each underflow raises uf_out and irq together for one clock cycle, in the cycle after the tick that caused the underflow.
- R6: In one-shot mode (oneshot = 1), running drops at the first underflow. Afterwards count stays at the reload value and no further pulses appear.
- R7: In repeat mode (oneshot = 0), the timer keeps underflowing until run_clr. After run_clr, running is 0 and count holds its value.
- R8: Underflow periods are numbered by a slot index s, which starts at 0 after preset and wraps from 15 back to 0. Period s is reload+2 ticks long when the bit-reversed 4-bit value of s is below fine, and reload+1 ticks long otherwise.
- R9: Any 16 consecutive periods that start at slot 0 total exactly (reload+1)*16 + fine ticks.
- R10: When run_clr and run_set arrive in the same cycle, run_clr wins and the timer ends up stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-clock enable, one count per high cycle |
| preset | input | 1 | Strobe that loads reload_val into the counter and clears the slot index |
| run_set | input | 1 | Strobe that starts counting |
| run_clr | input | 1 | Strobe that stops counting |
| oneshot | input | 1 | 1 selects one-shot mode, 0 selects repeat mode |
| reload_val | input | 8 | Reload value, 0 to 255 |
| fine | input | 4 | Number of stretched periods in each group of 16 |
| uf_out | output | 1 | Underflow pulse used as the serial bit-rate clock |
| irq | output | 1 | Timer interrupt request pulse |
| count | output | 8 | Current counter value |
| running | output | 1 | Run status, cleared by hardware in one-shot mode |

## Verification
The bench measures the length of every period in ticks against the bit-reversed slot rule. A design that stretched the wrong slots, or that never wrapped the slot index, fails there even when the 16-period total is right. Reload 0 with the enable high on every cycle produces back-to-back pulses and a two-cycle stretched period, which exposes any off-by-one in the stretch hold. Sparse random enables catch a design that counts clocks instead of ticks. One-shot termination, the run_clr priority over run_set, and holding while stopped are driven directly. A wrong design there would keep pulsing, restart, or drift the count.

// File: rtl/frt_pkg.sv
package frt_pkg;

    // Control states of the timer
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_STRETCH = 2'd2
    } frt_state_e;

endpackage

// File: rtl/frt_down_counter.sv
module frt_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

endmodule

// File: rtl/frt_slot_sched.sv
module frt_slot_sched #(
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [FINE_W-1:0] fine,
    output logic              stretch_due
);

    logic [FINE_W-1:0] slot_q;
    logic [FINE_W-1:0] slot_rev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (clear) begin
            slot_q <= '0;
        end else if (advance) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Bit reversal spreads the stretched slots evenly over the group
    for (genvar gi = 0; gi < FINE_W; gi++) begin : g_rev
        assign slot_rev[gi] = slot_q[FINE_W-1-gi];
    end

    assign stretch_due = (slot_rev < fine);

endmodule

// File: rtl/frt_ctrl_fsm.sv
module frt_ctrl_fsm
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run_set,
    input  logic run_clr,
    input  logic preset,
    input  logic oneshot,
    input  logic cnt_zero,
    input  logic stretch_due,
    output logic running,
    output logic dec,
    output logic underflow
);

    frt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        dec       = 1'b0;
        underflow = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (run_set && !run_clr) begin
                    state_d = ST_COUNT;               // START
                end
            end
            ST_COUNT: begin
                if (run_clr) begin
                    state_d = ST_IDLE;                // HALT
                end else if (preset) begin
                    state_d = ST_COUNT;
                end else if (tick_en) begin
                    if (!cnt_zero) begin
                        dec = 1'b1;
                    end else if (stretch_due) begin
                        state_d = ST_STRETCH;         // HOLD
                    end else begin
                        underflow = 1'b1;
                        state_d   = oneshot ? ST_IDLE : ST_COUNT;  // SHOT_END / WRAP
                    end
                end
            end
            ST_STRETCH: begin
                if (run_clr) begin
                    state_d = ST_IDLE;                // HALT
                end else if (preset) begin
                    state_d = ST_COUNT;               // PRESET_ABORT
                end else if (tick_en) begin
                    underflow = 1'b1;
                    state_d   = oneshot ? ST_IDLE : ST_COUNT;      // SHOT_END / WRAP
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign running = (state_q != ST_IDLE);

endmodule

// File: rtl/frac_reload_timer.sv
module frac_reload_timer #(
    parameter int CNT_W  = 8,
    parameter int FINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              preset,
    input  logic              run_set,
    input  logic              run_clr,
    input  logic              oneshot,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [FINE_W-1:0] fine,
    output logic              uf_out,
    output logic              irq,
    output logic [CNT_W-1:0]  count,
    output logic              running
);

    logic cnt_zero;
    logic stretch_due;
    logic dec;
    logic underflow;
    logic pulse_q;

    frt_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .run_set     (run_set),
        .run_clr     (run_clr),
        .preset      (preset),
        .oneshot     (oneshot),
        .cnt_zero    (cnt_zero),
        .stretch_due (stretch_due),
        .running     (running),
        .dec         (dec),
        .underflow   (underflow)
    );

    frt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (preset | underflow),
        .dec        (dec),
        .reload_val (reload_val),
        .count      (count),
        .zero       (cnt_zero)
    );

    frt_slot_sched #(.FINE_W(FINE_W)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (preset),
        .advance     (underflow),
        .fine        (fine),
        .stretch_due (stretch_due)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= underflow;
        end
    end

    assign uf_out = pulse_q;
    assign irq    = pulse_q;

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             preset,
    input logic             run_clr,
    input logic             oneshot,
    input logic [CNT_W-1:0] reload_val,
    input logic [CNT_W-1:0] count,
    input logic             running,
    input logic             uf_out
);

    a_r1_no_pulse_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(running) |-> !uf_out);

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick_en) && !$past(preset)) |-> $stable(count));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(running) && $past(tick_en) && !$past(preset) && !$past(run_clr)
         && $past(count) != '0) |-> count == $past(count) - 1'b1);

    a_r4_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        uf_out |-> count == $past(reload_val));

    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_out && $past(oneshot)) |-> !running);

endmodule

bind frac_reload_timer frt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .preset     (preset),
    .run_clr    (run_clr),
    .oneshot    (oneshot),
    .reload_val (reload_val),
    .count      (count),
    .running    (running),
    .uf_out     (uf_out)
);

// File: tb/frac_reload_timer_tb.sv
`timescale 1ns/1ps
module frac_reload_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       preset = 1'b0;
    logic       run_set = 1'b0;
    logic       run_clr = 1'b0;
    logic       oneshot = 1'b0;
    logic [7:0] reload_val = 8'd0;
    logic [3:0] fine = 4'd0;
    logic       uf_out;
    logic       irq;
    logic [7:0] count;
    logic       running;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    frac_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .preset(preset),
        .run_set(run_set), .run_clr(run_clr), .oneshot(oneshot),
        .reload_val(reload_val), .fine(fine), .uf_out(uf_out), .irq(irq),
        .count(count), .running(running)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int stretch_of(input int slot, input int f);
        int rev = 0;
        for (int i = 0; i < 4; i++) rev |= ((slot >> i) & 1) << (3 - i);
        return (rev < f) ? 1 : 0;
    endfunction

    task automatic cyc(input bit t);
        @(negedge clk);
        tick_en = t;
        @(posedge clk);
        #1;
    endtask

    task automatic do_preset();
        @(negedge clk); tick_en = 0; preset = 1;
        @(posedge clk); #1; preset = 0;
    endtask

    task automatic do_run(input bit s, input bit c);
        @(negedge clk); tick_en = 0; run_set = s; run_clr = c;
        @(posedge clk); #1; run_set = 0; run_clr = 0;
    endtask

    // Repeat-mode measurement of nper periods (R4, R5, R8, R9)
    task automatic measure(input int r, input int f, input int nper, input bit dense);
        int ticks = 0, total = 0, slot = 0, p = 0, guard = 0;
        reload_val = 8'(r); fine = 4'(f); oneshot = 0;
        do_preset();                 // R2: slot index restarts at 0
        do_run(1, 0);
        while (p < nper && guard < 40000) begin
            bit t = dense ? 1'b1 : 1'($urandom_range(0, 1));
            cyc(t);
            guard++;
            if (t) ticks++;
            if (uf_out) begin
                chk(irq === 1'b1, "R5 irq with pulse", int'(irq), 1);
                chk(t == 1'b1, "R5 pulse follows tick", int'(t), 1);
                chk(ticks == r + 1 + stretch_of(slot, f), "R8 period length",
                    ticks, r + 1 + stretch_of(slot, f));
                if (f == 0) chk(count == 8'(r), "R4 reload", int'(count), r);
                total += ticks;
                if (p == 15) chk(total == (r + 1) * 16 + f, "R9 group total", total, (r + 1) * 16 + f);
                ticks = 0;
                slot = (slot + 1) % 16;
                p++;
            end
        end
        chk(p == nper, "R7 repeat keeps running", p, nper);
        do_run(0, 1);
        chk(running == 1'b0, "R7 stopped by run_clr", int'(running), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        #1;
        // R1 reset state
        chk(count == 0, "R1 count", int'(count), 0);
        chk(running == 0, "R1 running", int'(running), 0);
        chk(uf_out == 0 && irq == 0, "R1 pulses", int'(uf_out), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 preset, R3 hold while stopped
        reload_val = 8'd5;
        do_preset();
        chk(count == 5, "R2 preset load", int'(count), 5);
        repeat (3) cyc(1);
        chk(count == 5, "R3 hold while stopped", int'(count), 5);

        // R3 step down and hold without tick
        do_run(1, 0);
        repeat (3) cyc(1);
        chk(count == 2, "R3 step down", int'(count), 2);
        repeat (4) cyc(0);
        chk(count == 2, "R3 hold without tick", int'(count), 2);

        // R2 preset wins over a tick in the same cycle
        reload_val = 8'd9;
        @(negedge clk); tick_en = 1; preset = 1;
        @(posedge clk); #1; preset = 0;
        chk(count == 9, "R2 preset over tick", int'(count), 9);

        // R7 run_clr stops and holds
        do_run(0, 1);
        chk(running == 0, "R7 stop", int'(running), 0);
        repeat (3) cyc(1);
        chk(count == 9, "R7 hold after stop", int'(count), 9);

        // R10 run_clr beats run_set
        do_run(1, 1);
        chk(running == 0, "R10 clear priority", int'(running), 0);

        // R6 one-shot
        reload_val = 8'd3; fine = 4'd0; oneshot = 1;
        do_preset();
        do_run(1, 0);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            cyc(1);
            n++;
            if (uf_out) break;
        end
        chk(n == 4, "R6 one-shot period", n, 4);
        chk(running == 0, "R6 run cleared", int'(running), 0);
        chk(count == 3, "R6 count reloaded", int'(count), 3);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            cyc(1);
            if (uf_out) n++;
        end
        chk(n == 0, "R6 no further pulses", n, 0);
        chk(count == 3, "R6 count held", int'(count), 3);

        // Directed repeat-mode corners
        measure(2, 0, 20, 1'b1);    // R4 plain division
        measure(0, 0, 8, 1'b1);     // R4 back-to-back pulses
        measure(4, 8, 32, 1'b1);    // R8 alternating stretch, wrap
        measure(0, 15, 32, 1'b1);   // R8 R9 maximum fine at reload 0
        measure(7, 1, 17, 1'b0);    // R8 single stretch, sparse ticks

        // Constrained random trials
        for (int k = 0; k < 6; k++) begin
            measure(int'($urandom_range(0, 40)), int'($urandom_range(0, 15)),
                    32, 1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule